// File: doc/BRIEF.md
# Instruction Prefetch Buffer Aligner

This block sits between the memory bus and the decode stage of a 32-bit processor whose instructions are a whole number of bytes long and may start at any byte address. Fetched words land in an eight-slot word buffer, and each slot has its own valid flag. Three byte-address pointers drive the block. The fetch pointer tells memory which word to bring next. The next pointer marks the first byte of the instruction about to be decoded. The current pointer holds the start of the instruction most recently retired into execution.

From the slot under the next pointer and the slot after it, the block aligns the byte stream with a funnel shift. A one-hot byte-lane code steers that shift. The opcode byte and a short register index are presented combinationally, together with the empty, full and opcode-valid flags. When decode advances, the current pointer takes the next pointer, and the next pointer steps forward by the instruction length. At the same moment the operand bytes that follow the opcode are latched, zero-extended according to that length. Slots whose words have been fully consumed are released for refilling. Loading a new PC from the result bus restarts the stream and flushes the buffer.

Top module: `ipb_prefetch_aligner`

## Requirements
- R1: After reset, cur_pc, next_pc and fetch_pc are zero, no slot is valid, buf_empty is 1, op_valid and buf_full are 0, and operand_zx is zero.
- R2: buf_empty is 1 exactly when the slot selected by next_pc[4:2] is not valid, and op_valid is always its complement.
- R3: A write taken without a PC load in the same cycle while the buffer is not full stores wr_data in slot fetch_pc[4:2], marks that slot valid and adds 4 to fetch_pc. buf_full is 1 only while all 8 slots are valid.
- R4: A write while buf_full is 1 is ignored: fetch_pc and every buffered word keep their values.
- R5: A PC load sets next_pc and fetch_pc to pc_value and clears all valid flags. In the same cycle it overrides any write or advance, and cur_pc keeps its value.
- R6: An advance without a PC load moves next_pc into cur_pc and adds adv_len (0 to 7 bytes) to next_pc.
- R7: An advance clears the valid flag of every word from the word holding the old next_pc up to, but not including, the word holding the new next_pc.
- R8: Byte k (k = 0..3) of a buffered word sits at bits 8k+7..8k, and has the byte address 4*word+k. opcode is the byte at next_pc. The byte offset next_pc[1:0] = 0, 1, 2, 3 selects the lane code 1000, 0100, 0010, 0001, which funnel-shifts the pair {following word, word} right by 0, 8, 16 or 24 bits.
- R9: reg_index is the byte at next_pc+1, which comes from the following slot when the offset is 3.
- R10: On an advance, operand_zx takes the bytes at next_pc+1 to next_pc+4, with the lowest address in bits 7:0. It keeps 4 bytes for lengths 0 and 1, 3 bytes for length 2, 2 for length 3, 1 for length 4 and none for 5 to 7, and the dropped upper bytes are zero. Without an advance it holds its value.
- R11: fetch_word_addr always equals fetch_pc shifted right by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the fetched word into the buffer |
| wr_data | input | 32 | Fetched word from the external bus |
| pc_load | input | 1 | Load a new PC from the result bus |
| pc_value | input | 32 | New PC value |
| adv | input | 1 | Advance decode by one instruction |
| adv_len | input | 3 | Length in bytes of the instruction being advanced past |
| cur_pc | output | 32 | Address of the instruction last advanced past |
| next_pc | output | 32 | Address of the instruction being decoded |
| fetch_pc | output | 32 | Byte address of the next word to fetch |
| fetch_word_addr | output | 30 | Word address sent to memory |
| buf_empty | output | 1 | Slot under next_pc holds no valid word |
| buf_full | output | 1 | All slots valid |
| op_valid | output | 1 | Opcode byte at next_pc is available |
| opcode | output | 8 | Aligned opcode byte |
| reg_index | output | 8 | Byte following the opcode |
| operand_zx | output | 32 | Zero-extended operand latched on advance |

## Verification
The main sweep fills the buffer with words whose bytes are an arithmetic function of their byte address, then advances through every length from 0 to 7 in a rotating order. Each step refills only as many words as the model says were consumed. The rotation makes every byte offset meet every length, which separates the four lanes of the funnel shift and the five operand masks. An opcode or operand at offset 3 tells apart a design that reads the following slot from one that wraps inside a single word. Waiting for buf_full after each exact-count refill exposes a release of too many or too few slots. A second run starts from a PC load to an odd address, issued together with a write and an advance. This shows that the load flushes the buffer and wins over both, and that the stream can then be rebuilt from a misaligned start.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned LANES  = 4;

   // one-hot steering code: offset 0 selects the top lane bit
   function automatic logic [LANES-1:0] lane_onehot(input logic [1:0] off);
      lane_onehot = 4'b1000 >> off;
   endfunction

   // bit b set keeps operand byte b; upper bytes are dropped as length grows
   function automatic logic [LANES-1:0] keep_code(input int unsigned len);
      if (len <= 1)
         keep_code = 4'hF;
      else if (len >= 5)
         keep_code = 4'h0;
      else
         keep_code = 4'hF >> (len - 1);
   endfunction
endpackage

// File: rtl/ipb_ptrs.sv
module ipb_ptrs #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned LEN_W = 3,
   parameter int unsigned STEP  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pc_load,
   input  logic [PC_W-1:0]  pc_value,
   input  logic             adv,
   input  logic [LEN_W-1:0] adv_len,
   input  logic             wr_accept,
   output logic [PC_W-1:0]  cur_pc,
   output logic [PC_W-1:0]  next_pc,
   output logic [PC_W-1:0]  fetch_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_pc   <= '0;
         next_pc  <= '0;
         fetch_pc <= '0;
      end else if (pc_load) begin
         next_pc  <= pc_value;
         fetch_pc <= pc_value;
      end else begin
         if (adv) begin
            cur_pc  <= next_pc;
            next_pc <= next_pc + PC_W'(adv_len);
         end
         if (wr_accept)
            fetch_pc <= fetch_pc + PC_W'(STEP);
      end
   end

   AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !pc_load |=> cur_pc == $past(next_pc)
                          && next_pc == $past(next_pc) + PC_W'($past(adv_len))); // R6
   AST_LOAD_POINTERS: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> next_pc == $past(pc_value) && fetch_pc == $past(pc_value)
                  && $stable(cur_pc)); // R5
endmodule

// File: rtl/ipb_store.sv
module ipb_store #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned SLOT_W   = 3,
   parameter int unsigned SPAN_W   = 2,
   parameter int unsigned MAX_SPAN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_load,
   input  logic              wr_accept,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              adv_accept,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [SPAN_W-1:0] span,
   output logic [DEPTH-1:0]  valid_q,
   output logic [WORD_W-1:0] rd_word,
   output logic [WORD_W-1:0] nx_word
);
   logic [WORD_W-1:0] words_q [DEPTH];
   logic [DEPTH-1:0]  valid_d;
   logic [SLOT_W-1:0] nx_slot;

   assign nx_slot = rd_slot + SLOT_W'(1);
   assign rd_word = words_q[rd_slot];
   assign nx_word = words_q[nx_slot];

   always_comb begin
      valid_d = valid_q;
      if (adv_accept) begin
         for (int k = 0; k < MAX_SPAN; k++) begin
            if (SPAN_W'(k) < span)
               valid_d[rd_slot + SLOT_W'(k)] = 1'b0;
         end
      end
      if (wr_accept)
         valid_d[wr_slot] = 1'b1;
      if (pc_load)
         valid_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         valid_q <= '0;
      else
         valid_q <= valid_d;
   end

   always_ff @(posedge clk) begin
      if (wr_accept)
         words_q[wr_slot] <= wr_data;
   end

   AST_LOAD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> valid_q == '0); // R5
   AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept && !pc_load |=> valid_q[$past(wr_slot)]); // R3
   AST_CONSUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      adv_accept && !pc_load && !wr_accept && span != '0 |=> !valid_q[$past(rd_slot)]); // R7
endmodule

// File: rtl/ipb_align.sv
module ipb_align #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0]         cur_w,
   input  logic [WORD_W-1:0]         nx_w,
   input  logic [1:0]                off,
   output logic [ipb_pkg::BYTE_W-1:0] opcode,
   output logic [WORD_W-1:0]         operand_raw
);
   import ipb_pkg::*;
   localparam int unsigned PAIR_W = 2 * WORD_W;

   logic [PAIR_W-1:0] pair;
   logic [LANES-1:0]  lane;
   logic [PAIR_W-1:0] cand [LANES];
   logic [PAIR_W-1:0] sel;

   assign pair = {nx_w, cur_w};
   assign lane = lane_onehot(off);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cand[l] = pair >> (BYTE_W * (LANES - 1 - l));
   end

   always_comb begin
      sel = '0;
      for (int l = 0; l < LANES; l++)
         sel = sel | (cand[l] & {PAIR_W{lane[l]}});
   end

   assign opcode      = sel[BYTE_W-1:0];
   assign operand_raw = sel[BYTE_W +: WORD_W];
endmodule

// File: rtl/ipb_operand.sv
module ipb_operand #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_accept,
   input  logic [LEN_W-1:0]  adv_len,
   input  logic [WORD_W-1:0] operand_raw,
   output logic [WORD_W-1:0] operand_q
);
   import ipb_pkg::*;

   logic [LANES-1:0]  keep;
   logic [WORD_W-1:0] masked;

   assign keep = keep_code(int'(adv_len));

   for (genvar b = 0; b < LANES; b++) begin : g_byte
      assign masked[b*BYTE_W +: BYTE_W] =
         keep[b] ? operand_raw[b*BYTE_W +: BYTE_W] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         operand_q <= '0;
      else if (adv_accept)
         operand_q <= masked;
   end

   AST_LONG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      adv_accept && adv_len >= LEN_W'(5) |=> operand_q == '0); // R10
   AST_LEN4_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      adv_accept && adv_len == LEN_W'(4) |=> operand_q[WORD_W-1:BYTE_W] == '0); // R10
   AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_accept |=> $stable(operand_q)); // R10
endmodule

// File: rtl/ipb_prefetch_aligner.sv
module ipb_prefetch_aligner #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wr_data,
   input  logic             pc_load,
   input  logic [PC_W-1:0]  pc_value,
   input  logic             adv,
   input  logic [LEN_W-1:0] adv_len,
   output logic [PC_W-1:0]  cur_pc,
   output logic [PC_W-1:0]  next_pc,
   output logic [PC_W-1:0]  fetch_pc,
   output logic [PC_W-3:0]  fetch_word_addr,
   output logic             buf_empty,
   output logic             buf_full,
   output logic             op_valid,
   output logic [7:0]       opcode,
   output logic [7:0]       reg_index,
   output logic [31:0]      operand_zx
);
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned STEP     = WORD_W / 8;
   localparam int unsigned SLOT_W   = $clog2(DEPTH);
   localparam int unsigned MAX_LEN  = (1 << LEN_W) - 1;
   localparam int unsigned MAX_SPAN = (MAX_LEN + STEP - 1) / STEP;
   localparam int unsigned SPAN_W   = $clog2(MAX_SPAN + 1);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (PC_W > SLOT_W + 2)
         else $error("PC_W too narrow for the slot index");
      assert (LEN_W >= 1 && LEN_W <= 4)
         else $error("LEN_W out of range");
   end

   logic              wr_accept, adv_accept;
   logic [DEPTH-1:0]  valid_q;
   logic [SLOT_W-1:0] rd_slot, wr_slot;
   logic [PC_W-1:0]   adv_end;
   logic [SPAN_W-1:0] span;
   logic [WORD_W-1:0] rd_word, nx_word, operand_raw;

   assign wr_accept  = wr_en & ~buf_full & ~pc_load;
   assign adv_accept = adv & ~pc_load;
   assign rd_slot    = next_pc[SLOT_W+1:2];
   assign wr_slot    = fetch_pc[SLOT_W+1:2];
   assign adv_end    = next_pc + PC_W'(adv_len);
   assign span       = SPAN_W'(adv_end[PC_W-1:2] - next_pc[PC_W-1:2]);

   ipb_ptrs #(.PC_W(PC_W), .LEN_W(LEN_W), .STEP(STEP)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
      .adv(adv), .adv_len(adv_len), .wr_accept(wr_accept),
      .cur_pc(cur_pc), .next_pc(next_pc), .fetch_pc(fetch_pc)
   );

   ipb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W),
               .SPAN_W(SPAN_W), .MAX_SPAN(MAX_SPAN)) u_store (
      .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .wr_accept(wr_accept),
      .wr_slot(wr_slot), .wr_data(wr_data), .adv_accept(adv_accept),
      .rd_slot(rd_slot), .span(span), .valid_q(valid_q),
      .rd_word(rd_word), .nx_word(nx_word)
   );

   ipb_align #(.WORD_W(WORD_W)) u_align (
      .cur_w(rd_word), .nx_w(nx_word), .off(next_pc[1:0]),
      .opcode(opcode), .operand_raw(operand_raw)
   );

   ipb_operand #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_operand (
      .clk(clk), .rst_n(rst_n), .adv_accept(adv_accept), .adv_len(adv_len),
      .operand_raw(operand_raw), .operand_q(operand_zx)
   );

   assign reg_index       = operand_raw[7:0];
   assign buf_empty       = ~valid_q[rd_slot];
   assign op_valid        = valid_q[rd_slot];
   assign buf_full        = &valid_q;
   assign fetch_word_addr = fetch_pc[PC_W-1:2];

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty != op_valid); // R2
   AST_FULL_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && buf_full && !pc_load |=> $stable(fetch_pc)); // R4
   AST_OPCODE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> opcode == rd_word[8*next_pc[1:0] +: 8]); // R8
endmodule

// File: tb/sim_ipb_prefetch_aligner.sv
`timescale 1ns/1ps
module sim_ipb_prefetch_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        pc_load = 1'b0;
   logic [31:0] pc_value = '0;
   logic        adv = 1'b0;
   logic [2:0]  adv_len = '0;
   logic [31:0] cur_pc, next_pc, fetch_pc, operand_zx;
   logic [29:0] fetch_word_addr;
   logic        buf_empty, buf_full, op_valid;
   logic [7:0]  opcode, reg_index;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_cur, m_nxt, m_fch;

   always #2 clk = ~clk;

   ipb_prefetch_aligner u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .pc_load(pc_load), .pc_value(pc_value), .adv(adv), .adv_len(adv_len),
      .cur_pc(cur_pc), .next_pc(next_pc), .fetch_pc(fetch_pc),
      .fetch_word_addr(fetch_word_addr), .buf_empty(buf_empty),
      .buf_full(buf_full), .op_valid(op_valid), .opcode(opcode),
      .reg_index(reg_index), .operand_zx(operand_zx)
   );

   function automatic logic [7:0] bt(input logic [31:0] a);
      bt = 8'(a * 29 + 5);
   endfunction

   function automatic logic [31:0] word_at(input logic [31:0] wa);
      word_at = {bt(4*wa+3), bt(4*wa+2), bt(4*wa+1), bt(4*wa)};
   endfunction

   function automatic logic [31:0] op_exp(input logic [31:0] a, input int len);
      int keep;
      keep = (len <= 1) ? 4 : ((len >= 5) ? 0 : 5 - len);
      op_exp = '0;
      for (int b = 0; b < keep; b++)
         op_exp[8*b +: 8] = bt(a + 1 + b);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic write_word;
      wr_en   = 1'b1;
      wr_data = word_at(m_fch >> 2);
      tick;
      wr_en = 1'b0;
      m_fch = m_fch + 4;
      chk(fetch_pc == m_fch, "R3 fetch_pc step", fetch_pc, m_fch);
      chk(fetch_word_addr == m_fch[31:2], "R11 word addr", 32'(fetch_word_addr), m_fch >> 2);
   endtask

   task automatic fill;
      while ((m_fch >> 2) - (m_nxt >> 2) < 8)
         write_word;
      chk(buf_full == 1'b1, "R3 full after fill", 32'(buf_full), 1);
   endtask

   task automatic run_steps(input int n, input int seed);
      for (int s = 0; s < n; s++) begin
         int len;
         logic [31:0] words_left;
         len = (s * 5 + seed) % 8;
         chk(op_valid == 1'b1 && buf_empty == 1'b0, "R2 valid at read slot",
             {30'd0, op_valid, buf_empty}, 32'h2);
         chk(opcode == bt(m_nxt), "R8 opcode", 32'(opcode), 32'(bt(m_nxt)));
         chk(reg_index == bt(m_nxt + 1), "R9 reg index", 32'(reg_index), 32'(bt(m_nxt + 1)));
         adv = 1'b1;
         adv_len = 3'(len);
         tick;
         adv = 1'b0;
         chk(operand_zx == op_exp(m_nxt, len), "R10 operand", operand_zx, op_exp(m_nxt, len));
         m_cur = m_nxt;
         m_nxt = m_nxt + 32'(len);
         chk(cur_pc == m_cur, "R6 cur_pc", cur_pc, m_cur);
         chk(next_pc == m_nxt, "R6 next_pc", next_pc, m_nxt);
         words_left = (m_fch >> 2) - (m_nxt >> 2);
         chk(buf_full == (words_left == 8), "R7 release count", 32'(buf_full),
             32'(words_left == 8));
         tick;
         chk(operand_zx == op_exp(m_cur, len), "R10 operand hold", operand_zx,
             op_exp(m_cur, len));
         fill;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick; tick; tick;
      rst_n = 1'b1;
      m_cur = 0; m_nxt = 0; m_fch = 0;
      // R1 reset state
      chk(cur_pc == 0 && next_pc == 0 && fetch_pc == 0, "R1 pointers", next_pc, 0);
      chk(buf_empty == 1'b1 && op_valid == 1'b0, "R1 empty", 32'(buf_empty), 1);
      chk(buf_full == 1'b0, "R1 full", 32'(buf_full), 0);
      chk(operand_zx == 0, "R1 operand", operand_zx, 0);

      fill;
      // R4 write while full is ignored
      wr_en = 1'b1;
      wr_data = 32'hDEAD_BEEF;
      tick;
      wr_en = 1'b0;
      chk(fetch_pc == m_fch, "R4 fetch_pc held", fetch_pc, m_fch);
      chk(opcode == bt(0), "R4 contents kept", 32'(opcode), 32'(bt(0)));

      run_steps(48, 3);

      // R5 load wins over write and advance in the same cycle
      pc_load = 1'b1; pc_value = 32'h0000_0103;
      wr_en = 1'b1; wr_data = 32'h1234_5678;
      adv = 1'b1; adv_len = 3'd2;
      tick;
      pc_load = 1'b0; wr_en = 1'b0; adv = 1'b0;
      chk(next_pc == 32'h103 && fetch_pc == 32'h103, "R5 pointers loaded", fetch_pc, 32'h103);
      chk(cur_pc == m_cur, "R5 cur_pc kept", cur_pc, m_cur);
      chk(buf_empty == 1'b1 && buf_full == 1'b0, "R5 flushed", {31'd0, buf_empty}, 1);
      chk(fetch_word_addr == 30'h40, "R11 after load", 32'(fetch_word_addr), 32'h40);
      m_nxt = 32'h103; m_fch = 32'h103;
      write_word;
      chk(op_valid == 1'b1, "R2 valid after first word", 32'(op_valid), 1);
      chk(opcode == bt(32'h103), "R8 offset 3 opcode", 32'(opcode), 32'(bt(32'h103)));
      fill;
      run_steps(24, 6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule